// File: doc/BRIEF.md
# Streaming Video Color Conversion Pipeline

This block converts a stream of RGB pixels into YUV and shapes it for a narrower output link. It moves one pixel per beat over a valid/ready handshake. Each beat carries a start-of-frame marker and an end-of-line marker.

The work is done in three stages, always in the same order:
1. Color-space conversion with a single range flag. The flag sets both the matrix offsets and the clamp window, so the two cannot disagree.
2. An optional horizontal chroma reduction from 4:4:4 to 4:2:2.
3. A single quantization point at the very end. An optional ordered dither is added there just before the bits are dropped.

Every stage can be bypassed through static mode inputs. The mode inputs may only change while the pipeline is empty. Backpressure passes through all stages without losing or repeating a pixel. Internal samples are DW bits wide (default 12).

Top module: `vcp_color_pipe`

## Requirements
- R1: Every accepted input pixel leaves as exactly one output pixel, in order, with its start-of-frame and end-of-line markers unchanged. This holds for any pattern of input gaps and output stalls.
- R2: While `m_valid` is high and `m_ready` is low, the output beat (markers and all three fields) stays unchanged on the next cycle.
- R3: With conversion on and `cfg_limited`=0, the fields are computed from integer dot products with Q10 weights. Y uses (218,732,74) on (R,G,B). Cb uses (-117,-395,512). Cr uses (512,-465,-47). Each sum is rounded as floor((sum+512)/1024). Cb and Cr get 2^(DW-1) added. Every result is clamped to 0..2^DW-1.
- R4: With conversion on and `cfg_limited`=1, Y uses (187,629,64), Cb uses (-103,-347,450) and Cr uses (450,-408,-42), rounded the same way. Y gets 16·2^(DW-8) added and is clamped to 16..235 at 8-bit scale. Cb and Cr get 2^(DW-1) added and are clamped to 16..240 at 8-bit scale.
- R5: With conversion off, R, G and B pass unchanged into fields Y, C1 and C2.
- R6: With `cfg_sub422`=1, pixels in a line are paired from the line start. Both pixels of a pair keep their own Y. The first pixel's C1 is the rounded mean (a+b+1)>>1 of the pair's Cb values. The second pixel's C1 is the rounded mean of the pair's Cr values. C2 is 0 before quantization. A lone last pixel of an odd-length line keeps its own Cb in C1.
- R7: With `cfg_sub422`=0, all three fields pass the chroma stage unchanged.
- R8: `cfg_depth` selects the output width: 0 gives 8 bits, 1 gives 10 bits, 2 and 3 give 12 bits. The result is right-aligned in the DW-bit field as the value shifted right by DW minus the width.
- R9: With `cfg_dither`=1 and at least 2 bits dropped, an offset is added before the shift. The offset is B<<(dropped-2), where B is 0,2,3,1 for (y even, x even), (y even, x odd), (y odd, x even), (y odd, x odd). x counts pixels from the line start. y counts lines from the frame start. A start-of-frame beat is x=0, y=0.
- R10: If the dither offset carries past 2^DW-1, the value saturates to the largest code of the selected width.
- R11: With `cfg_dither`=0, the reduction is plain truncation.
- R12: After reset, `m_valid` is low and `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_csc_en | input | 1 | Enable RGB to YUV conversion |
| cfg_limited | input | 1 | Limited-range mapping when 1, full range when 0 |
| cfg_sub422 | input | 1 | 4:2:2 chroma reduction when 1, 4:4:4 passthrough when 0 |
| cfg_dither | input | 1 | Ordered dither before truncation |
| cfg_depth | input | 2 | Output width select (8/10/12) |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Pipeline can take a beat |
| s_sof | input | 1 | Input start of frame |
| s_eol | input | 1 | Input end of line |
| s_r | input | DW | Red sample |
| s_g | input | DW | Green sample |
| s_b | input | DW | Blue sample |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts the beat |
| m_sof | output | 1 | Output start of frame |
| m_eol | output | 1 | Output end of line |
| m_y | output | DW | Luma (or R in bypass) |
| m_c1 | output | DW | Cb/Cr field (alternating in 4:2:2) |
| m_c2 | output | DW | Cr field, or zero-based in 4:2:2 |

## Verification
The bench builds the block with DW=12 and dither present, which gives the 8-, 10- and 12-bit output widths the requirements name. At 8 bits the full 4-bit dither offset range is in use. At 12 bits no bits are dropped, so the limited-range clamp window is visible code for code at the output. Because DW is 12, the extreme inputs 0 and 4095 reach both clamp edges and the saturation point at the top of the dither adder.

// File: rtl/vcp_pkg.sv
package vcp_pkg;

   localparam int COEF_FRAC = 10;

   // Row-major weights: Y row, Cb row, Cr row; columns R, G, B.
   localparam int FULL_K [9] = '{218, 732, 74, -117, -395, 512, 512, -465, -47};
   localparam int LIM_K  [9] = '{187, 629, 64, -103, -347, 450, 450, -408, -42};

   typedef enum logic [2:0] {
      CH_IDLE,
      CH_HALF,
      CH_EMIT_E,
      CH_EMIT_O,
      CH_SOLO,
      CH_PASS
   } chroma_state_t;

   function automatic int depth_shift(input logic [1:0] code, input int dw);
      case (code)
         2'd0:    return dw - 8;
         2'd1:    return dw - 10;
         default: return dw - 12;
      endcase
   endfunction

   function automatic logic [1:0] bayer2(input logic yp, input logic xp);
      case ({yp, xp})
         2'b00:   return 2'd0;
         2'b01:   return 2'd2;
         2'b10:   return 2'd3;
         default: return 2'd1;
      endcase
   endfunction

endpackage

// File: rtl/vcp_csc.sv
module vcp_csc #(
   parameter int DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          lim,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic          in_sof,
   input  logic          in_eol,
   input  logic [DW-1:0] in_a,
   input  logic [DW-1:0] in_b,
   input  logic [DW-1:0] in_c,
   output logic          out_valid,
   input  logic          out_ready,
   output logic          out_sof,
   output logic          out_eol,
   output logic [DW-1:0] out_a,
   output logic [DW-1:0] out_b,
   output logic [DW-1:0] out_c
);
   import vcp_pkg::*;

   localparam int LSH   = DW - 8;
   localparam logic signed [31:0] MAXV  = (32'sd1 <<< DW) - 32'sd1;
   localparam logic signed [31:0] MID   = 32'sd1 <<< (DW - 1);
   localparam logic signed [31:0] Y_LO  = 32'sd16 <<< LSH;
   localparam logic signed [31:0] Y_HI  = 32'sd235 <<< LSH;
   localparam logic signed [31:0] C_LO  = 32'sd16 <<< LSH;
   localparam logic signed [31:0] C_HI  = 32'sd240 <<< LSH;
   localparam logic signed [31:0] HALF  = 32'sd1 <<< (COEF_FRAC - 1);

   function automatic logic signed [31:0] ext(input logic [DW-1:0] v);
      return $signed({{(32 - DW){1'b0}}, v});
   endfunction

   logic [DW-1:0] src [3];
   logic [DW-1:0] res [3];

   assign src[0] = in_a;
   assign src[1] = in_b;
   assign src[2] = in_c;

   always_comb begin
      for (int r = 0; r < 3; r++) begin
         logic signed [31:0] acc, v, lo, hi;
         acc = '0;
         for (int c = 0; c < 3; c++) begin
            acc = acc + (lim ? LIM_K[3*r+c] : FULL_K[3*r+c]) * ext(src[c]);
         end
         v = (acc + HALF) >>> COEF_FRAC;
         if (r == 0) begin
            v  = v + (lim ? Y_LO : 32'sd0);
            lo = lim ? Y_LO : 32'sd0;
            hi = lim ? Y_HI : MAXV;
         end else begin
            v  = v + MID;
            lo = lim ? C_LO : 32'sd0;
            hi = lim ? C_HI : MAXV;
         end
         if (v < lo) v = lo;
         if (v > hi) v = hi;
         res[r] = en ? v[DW-1:0] : src[r];
      end
   end

   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_eol   <= 1'b0;
         out_a     <= '0;
         out_b     <= '0;
         out_c     <= '0;
      end else if (in_ready) begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_sof <= in_sof;
            out_eol <= in_eol;
            out_a   <= res[0];
            out_b   <= res[1];
            out_c   <= res[2];
         end
      end
   end

endmodule

// File: rtl/vcp_chroma.sv
module vcp_chroma #(
   parameter int DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic          in_sof,
   input  logic          in_eol,
   input  logic [DW-1:0] in_y,
   input  logic [DW-1:0] in_cb,
   input  logic [DW-1:0] in_cr,
   output logic          out_valid,
   input  logic          out_ready,
   output logic          out_sof,
   output logic          out_eol,
   output logic [DW-1:0] out_y,
   output logic [DW-1:0] out_c1,
   output logic [DW-1:0] out_c2
);
   import vcp_pkg::*;

   typedef struct packed {
      logic          sof;
      logic          eol;
      logic [DW-1:0] y;
      logic [DW-1:0] cb;
      logic [DW-1:0] cr;
   } px_t;

   chroma_state_t st, st_nx;
   px_t           ev, od, inpx;
   logic [DW:0]   avg_cb, avg_cr;
   logic          in_fire, load_ev;

   assign inpx    = '{sof: in_sof, eol: in_eol, y: in_y, cb: in_cb, cr: in_cr};
   assign avg_cb  = ({1'b0, ev.cb} + {1'b0, od.cb} + {{DW{1'b0}}, 1'b1}) >> 1;
   assign avg_cr  = ({1'b0, ev.cr} + {1'b0, od.cr} + {{DW{1'b0}}, 1'b1}) >> 1;

   always_comb begin
      out_valid = 1'b0;
      in_ready  = 1'b0;
      out_sof   = ev.sof;
      out_eol   = ev.eol;
      out_y     = ev.y;
      out_c1    = ev.cb;
      out_c2    = '0;
      case (st)
         CH_IDLE, CH_HALF: in_ready = 1'b1;
         CH_EMIT_E: begin
            out_valid = 1'b1;
            out_c1    = avg_cb[DW-1:0];
         end
         CH_EMIT_O: begin
            out_valid = 1'b1;
            in_ready  = out_ready;
            out_sof   = od.sof;
            out_eol   = od.eol;
            out_y     = od.y;
            out_c1    = avg_cr[DW-1:0];
         end
         CH_SOLO: begin
            out_valid = 1'b1;
            in_ready  = out_ready;
         end
         CH_PASS: begin
            out_valid = 1'b1;
            in_ready  = out_ready;
            out_c2    = ev.cr;
         end
         default: ;
      endcase
   end

   assign in_fire = in_valid && in_ready;
   assign load_ev = in_fire && (st != CH_HALF);

   always_comb begin
      st_nx = st;
      if (load_ev) begin
         if (!en)         st_nx = CH_PASS;
         else if (in_eol) st_nx = CH_SOLO;
         else             st_nx = CH_HALF;
      end else begin
         case (st)
            CH_HALF:   if (in_fire)   st_nx = CH_EMIT_E;
            CH_EMIT_E: if (out_ready) st_nx = CH_EMIT_O;
            CH_EMIT_O, CH_SOLO, CH_PASS:
                       if (out_ready) st_nx = CH_IDLE;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= CH_IDLE;
         ev <= '0;
         od <= '0;
      end else begin
         st <= st_nx;
         if (load_ev) ev <= inpx;
         if (in_fire && st == CH_HALF) od <= inpx;
      end
   end

endmodule

// File: rtl/vcp_quant.sv
module vcp_quant #(
   parameter int DW         = 12,
   parameter bit HAS_DITHER = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dith_en,
   input  logic [1:0]    depth,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic          in_sof,
   input  logic          in_eol,
   input  logic [DW-1:0] in_y,
   input  logic [DW-1:0] in_c1,
   input  logic [DW-1:0] in_c2,
   output logic          out_valid,
   input  logic          out_ready,
   output logic          out_sof,
   output logic          out_eol,
   output logic [DW-1:0] out_y,
   output logic [DW-1:0] out_c1,
   output logic [DW-1:0] out_c2
);
   import vcp_pkg::*;

   logic          xp, yp, cur_x, cur_y, dith_on, in_fire;
   logic [DW:0]   off;
   logic [DW-1:0] src [3];
   logic [DW-1:0] q   [3];
   int            sh;

   generate
      if (HAS_DITHER) begin : g_dither
         assign dith_on = dith_en;
      end else begin : g_plain
         logic unused_dith;
         assign unused_dith = dith_en;
         assign dith_on     = 1'b0;
      end
   endgenerate

   assign cur_x  = in_sof ? 1'b0 : xp;
   assign cur_y  = in_sof ? 1'b0 : yp;
   assign sh     = depth_shift(depth, DW);
   assign src[0] = in_y;
   assign src[1] = in_c1;
   assign src[2] = in_c2;

   always_comb begin
      off = '0;
      if (dith_on && sh >= 2)
         off = {{(DW - 1){1'b0}}, bayer2(cur_y, cur_x)} << (sh - 2);
   end

   always_comb begin
      for (int f = 0; f < 3; f++) begin
         logic [DW:0]   sum;
         logic [DW-1:0] sat;
         sum  = {1'b0, src[f]} + off;
         sat  = sum[DW] ? {DW{1'b1}} : sum[DW-1:0];
         q[f] = sat >> sh;
      end
   end

   assign in_ready = !out_valid || out_ready;
   assign in_fire  = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_eol   <= 1'b0;
         out_y     <= '0;
         out_c1    <= '0;
         out_c2    <= '0;
         xp        <= 1'b0;
         yp        <= 1'b0;
      end else begin
         if (in_ready) out_valid <= in_valid;
         if (in_fire) begin
            out_sof <= in_sof;
            out_eol <= in_eol;
            out_y   <= q[0];
            out_c1  <= q[1];
            out_c2  <= q[2];
            xp      <= in_eol ? 1'b0 : ~cur_x;
            yp      <= in_eol ? ~cur_y : cur_y;
         end
      end
   end

endmodule

// File: rtl/vcp_color_pipe.sv
module vcp_color_pipe #(
   parameter int DW         = 12,
   parameter bit HAS_DITHER = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_csc_en,
   input  logic          cfg_limited,
   input  logic          cfg_sub422,
   input  logic          cfg_dither,
   input  logic [1:0]    cfg_depth,
   input  logic          s_valid,
   output logic          s_ready,
   input  logic          s_sof,
   input  logic          s_eol,
   input  logic [DW-1:0] s_r,
   input  logic [DW-1:0] s_g,
   input  logic [DW-1:0] s_b,
   output logic          m_valid,
   input  logic          m_ready,
   output logic          m_sof,
   output logic          m_eol,
   output logic [DW-1:0] m_y,
   output logic [DW-1:0] m_c1,
   output logic [DW-1:0] m_c2
);

   generate
      if (DW < 12 || DW > 16) begin : g_bad_dw
         $error("vcp_color_pipe: DW must lie in 12..16");
      end
   endgenerate

   logic          a_valid, a_ready, a_sof, a_eol;
   logic [DW-1:0] a_y, a_cb, a_cr;
   logic          b_valid, b_ready, b_sof, b_eol;
   logic [DW-1:0] b_y, b_c1, b_c2;

   vcp_csc #(.DW(DW)) u_csc (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (cfg_csc_en),
      .lim       (cfg_limited),
      .in_valid  (s_valid),
      .in_ready  (s_ready),
      .in_sof    (s_sof),
      .in_eol    (s_eol),
      .in_a      (s_r),
      .in_b      (s_g),
      .in_c      (s_b),
      .out_valid (a_valid),
      .out_ready (a_ready),
      .out_sof   (a_sof),
      .out_eol   (a_eol),
      .out_a     (a_y),
      .out_b     (a_cb),
      .out_c     (a_cr)
   );

   vcp_chroma #(.DW(DW)) u_chroma (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (cfg_sub422),
      .in_valid  (a_valid),
      .in_ready  (a_ready),
      .in_sof    (a_sof),
      .in_eol    (a_eol),
      .in_y      (a_y),
      .in_cb     (a_cb),
      .in_cr     (a_cr),
      .out_valid (b_valid),
      .out_ready (b_ready),
      .out_sof   (b_sof),
      .out_eol   (b_eol),
      .out_y     (b_y),
      .out_c1    (b_c1),
      .out_c2    (b_c2)
   );

   vcp_quant #(.DW(DW), .HAS_DITHER(HAS_DITHER)) u_quant (
      .clk       (clk),
      .rst_n     (rst_n),
      .dith_en   (cfg_dither),
      .depth     (cfg_depth),
      .in_valid  (b_valid),
      .in_ready  (b_ready),
      .in_sof    (b_sof),
      .in_eol    (b_eol),
      .in_y      (b_y),
      .in_c1     (b_c1),
      .in_c2     (b_c2),
      .out_valid (m_valid),
      .out_ready (m_ready),
      .out_sof   (m_sof),
      .out_eol   (m_eol),
      .out_y     (m_y),
      .out_c1    (m_c1),
      .out_c2    (m_c2)
   );

endmodule

// File: rtl/vcp_color_pipe_chk.sv
module vcp_color_pipe_chk #(
   parameter int DW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_csc_en,
   input logic          cfg_limited,
   input logic          cfg_sub422,
   input logic          cfg_dither,
   input logic [1:0]    cfg_depth,
   input logic          s_ready,
   input logic          m_valid,
   input logic          m_ready,
   input logic          m_sof,
   input logic          m_eol,
   input logic [DW-1:0] m_y,
   input logic [DW-1:0] m_c1,
   input logic [DW-1:0] m_c2
);
   import vcp_pkg::*;

   localparam int LSH = DW - 8;
   localparam logic [DW-1:0] Y_LO = DW'(16 << LSH);
   localparam logic [DW-1:0] Y_HI = DW'(235 << LSH);
   localparam logic [DW-1:0] C_LO = DW'(16 << LSH);
   localparam logic [DW-1:0] C_HI = DW'(240 << LSH);

   int            sh;
   logic [DW-1:0] cap;

   assign sh  = depth_shift(cfg_depth, DW);
   assign cap = {DW{1'b1}} >> sh;

   // R12: leaving reset, output empty and input open
   assert_reset_state_R12: assert property (@(posedge clk)
      $rose(rst_n) |-> (!m_valid && s_ready));

   // R2: a stalled beat is held unchanged
   assert_hold_stalled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable({m_sof, m_eol, m_y, m_c1, m_c2})));

   // R8: no output code exceeds the selected width
   assert_width_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> (m_y <= cap && m_c1 <= cap && m_c2 <= cap));

   // R4: limited window holds when no bits are dropped
   assert_limited_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && cfg_csc_en && cfg_limited && !cfg_sub422 && sh == 0)
      |-> (m_y >= Y_LO && m_y <= Y_HI && m_c1 >= C_LO && m_c1 <= C_HI
           && m_c2 >= C_LO && m_c2 <= C_HI));

   // R6: third field is empty in 4:2:2 without dither
   assert_c2_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && cfg_sub422 && !cfg_dither) |-> (m_c2 == '0));

endmodule

bind vcp_color_pipe vcp_color_pipe_chk #(.DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_csc_en  (cfg_csc_en),
   .cfg_limited (cfg_limited),
   .cfg_sub422  (cfg_sub422),
   .cfg_dither  (cfg_dither),
   .cfg_depth   (cfg_depth),
   .s_ready     (s_ready),
   .m_valid     (m_valid),
   .m_ready     (m_ready),
   .m_sof       (m_sof),
   .m_eol       (m_eol),
   .m_y         (m_y),
   .m_c1        (m_c1),
   .m_c2        (m_c2)
);

// File: tb/vcp_color_pipe_test.sv
module vcp_color_pipe_test;

   localparam int DW = 12;
   localparam int MAXV = 4095;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_csc_en = 1'b0, cfg_limited = 1'b0, cfg_sub422 = 1'b0, cfg_dither = 1'b0;
   logic [1:0]    cfg_depth = 2'd2;
   logic          s_valid = 1'b0, s_sof = 1'b0, s_eol = 1'b0;
   logic [DW-1:0] s_r = '0, s_g = '0, s_b = '0;
   logic          s_ready;
   logic          m_valid, m_sof, m_eol;
   logic          m_ready = 1'b0;
   logic [DW-1:0] m_y, m_c1, m_c2;

   always #4 clk = ~clk;

   vcp_color_pipe #(.DW(DW), .HAS_DITHER(1'b1)) uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_csc_en(cfg_csc_en), .cfg_limited(cfg_limited), .cfg_sub422(cfg_sub422),
      .cfg_dither(cfg_dither), .cfg_depth(cfg_depth),
      .s_valid(s_valid), .s_ready(s_ready), .s_sof(s_sof), .s_eol(s_eol),
      .s_r(s_r), .s_g(s_g), .s_b(s_b),
      .m_valid(m_valid), .m_ready(m_ready), .m_sof(m_sof), .m_eol(m_eol),
      .m_y(m_y), .m_c1(m_c1), .m_c2(m_c2)
   );

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   int unsigned seed = 32'h1234_5678;

   int  pr[$], pg[$], pb[$];
   bit  psof[$], peol[$];
   logic [3*DW+1:0] expq[$];

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: R1 run hung, got %0d cycles expected fewer", cycles);
         $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
         $finish;
      end
   end

   function automatic int rnd();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return int'(seed & 32'h7fff_ffff);
   endfunction

   function automatic int clampi(int v, int lo, int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   // R3 / R4 / R5 model from the stated weights
   function automatic void ref_csc(input int r, g, b, output int y, u, v);
      int ky[3], ku[3], kv[3];
      if (!cfg_csc_en) begin
         y = r; u = g; v = b;
         return;
      end
      if (cfg_limited) begin
         ky = '{187, 629, 64}; ku = '{-103, -347, 450}; kv = '{450, -408, -42};
      end else begin
         ky = '{218, 732, 74}; ku = '{-117, -395, 512}; kv = '{512, -465, -47};
      end
      y = (ky[0]*r + ky[1]*g + ky[2]*b + 512) >>> 10;
      u = ((ku[0]*r + ku[1]*g + ku[2]*b + 512) >>> 10) + 2048;
      v = ((kv[0]*r + kv[1]*g + kv[2]*b + 512) >>> 10) + 2048;
      if (cfg_limited) begin
         y = clampi(y + 256, 256, 3760);
         u = clampi(u, 256, 3840);
         v = clampi(v, 256, 3840);
      end else begin
         y = clampi(y, 0, MAXV);
         u = clampi(u, 0, MAXV);
         v = clampi(v, 0, MAXV);
      end
   endfunction

   function automatic int qnt(int val, int x, int y);
      int s, bt[4], o;
      bt = '{0, 2, 3, 1};
      s = (cfg_depth == 2'd0) ? 4 : (cfg_depth == 2'd1) ? 2 : 0;
      o = (cfg_dither && s >= 2) ? (bt[(y % 2) * 2 + (x % 2)] << (s - 2)) : 0;
      return clampi(val + o, 0, MAXV) >> s;
   endfunction

   task automatic add_px(int r, int g, int b, bit sof, bit eol);
      pr.push_back(r); pg.push_back(g); pb.push_back(b);
      psof.push_back(sof); peol.push_back(eol);
   endtask

   task automatic add_frame(int lines, int len, int mode, int cval);
      for (int l = 0; l < lines; l++)
         for (int x = 0; x < len; x++) begin
            if (mode == 0)
               add_px(rnd() % 4096, rnd() % 4096, rnd() % 4096, (l == 0 && x == 0), (x == len - 1));
            else
               add_px(cval, cval, cval, (l == 0 && x == 0), (x == len - 1));
         end
   endtask

   task automatic build_expected();
      int n, ys[$], us[$], vs[$], oy[$], o1[$], o2[$];
      bit os[$], oe[$];
      int y, u, v, i, px, py;
      n = pr.size();
      for (int k = 0; k < n; k++) begin
         ref_csc(pr[k], pg[k], pb[k], y, u, v);
         ys.push_back(y); us.push_back(u); vs.push_back(v);
      end
      i = 0;
      while (i < n) begin
         if (!cfg_sub422) begin
            oy.push_back(ys[i]); o1.push_back(us[i]); o2.push_back(vs[i]);
            os.push_back(psof[i]); oe.push_back(peol[i]); i++;
         end else if (peol[i]) begin
            oy.push_back(ys[i]); o1.push_back(us[i]); o2.push_back(0);
            os.push_back(psof[i]); oe.push_back(1'b1); i++;
         end else begin
            oy.push_back(ys[i]); o1.push_back((us[i] + us[i+1] + 1) / 2); o2.push_back(0);
            os.push_back(psof[i]); oe.push_back(peol[i]);
            oy.push_back(ys[i+1]); o1.push_back((vs[i] + vs[i+1] + 1) / 2); o2.push_back(0);
            os.push_back(psof[i+1]); oe.push_back(peol[i+1]);
            i += 2;
         end
      end
      px = 0; py = 0;
      for (int k = 0; k < oy.size(); k++) begin
         if (os[k]) begin px = 0; py = 0; end
         expq.push_back({os[k], oe[k], DW'(qnt(oy[k], px, py)),
                         DW'(qnt(o1[k], px, py)), DW'(qnt(o2[k], px, py))});
         if (oe[k]) begin px = 0; py++; end else px++;
      end
   endtask

   task automatic run_case(string tag, int vpct, int rpct);
      int idx, n, guard;
      bit stalled, vhold;
      logic [3*DW+1:0] held, act;
      build_expected();
      n = pr.size();
      idx = 0; guard = 0; stalled = 0; vhold = 0;
      while ((idx < n || expq.size() > 0) && guard < 20000) begin
         @(negedge clk);
         guard++;
         act = {m_sof, m_eol, m_y, m_c1, m_c2};
         if (stalled) begin
            tests++;
            if (!m_valid || act !== held) begin
               fails++;
               $display("FAIL R2 (%s): stalled beat changed, got %h expected %h", tag, act, held);
            end
         end
         if (idx < n) begin
            if (!vhold) vhold = (rnd() % 100) < vpct;
            s_valid = vhold;
            s_r = DW'(pr[idx]); s_g = DW'(pg[idx]); s_b = DW'(pb[idx]);
            s_sof = psof[idx]; s_eol = peol[idx];
         end else begin
            s_valid = 1'b0;
         end
         m_ready = (rnd() % 100) < rpct;
         #1;
         act = {m_sof, m_eol, m_y, m_c1, m_c2};
         stalled = m_valid && !m_ready;
         held = act;
         if (m_valid && m_ready) begin
            tests++;
            if (expq.size() == 0) begin
               fails++;
               $display("FAIL R1 (%s): extra beat, got %h expected none", tag, act);
            end else begin
               if (act !== expq[0]) begin
                  fails++;
                  $display("FAIL %s: got %h expected %h", tag, act, expq[0]);
               end
               void'(expq.pop_front());
            end
         end
         if (s_valid && s_ready) begin
            idx++;
            vhold = 0;
         end
      end
      @(negedge clk);
      s_valid = 1'b0; m_ready = 1'b0;
      tests++;
      if (expq.size() != 0 || idx != n || m_valid) begin
         fails++;
         $display("FAIL R1 (%s): got %0d left, %0d sent, expected 0 left, %0d sent",
                  tag, expq.size(), idx, n);
      end
      pr.delete(); pg.delete(); pb.delete(); psof.delete(); peol.delete(); expq.delete();
   endtask

   task automatic set_cfg(bit csc, bit lim, bit sub, bit dith, logic [1:0] dep);
      cfg_csc_en = csc; cfg_limited = lim; cfg_sub422 = sub;
      cfg_dither = dith; cfg_depth = dep;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      tests++;
      if (m_valid !== 1'b0 || s_ready !== 1'b1) begin
         fails++;
         $display("FAIL R12: got valid=%b ready=%b expected valid=0 ready=1", m_valid, s_ready);
      end

      // R5 R7 R11: full bypass at 12 bits
      set_cfg(0, 0, 0, 0, 2'd2);
      add_frame(2, 6, 0, 0);
      run_case("R5/R7", 70, 60);

      // R3: full range, extremes and primaries
      set_cfg(1, 0, 0, 0, 2'd2);
      add_px(0, 0, 0, 1, 0); add_px(4095, 4095, 4095, 0, 0);
      add_px(4095, 0, 0, 0, 0); add_px(0, 4095, 0, 0, 0);
      add_px(0, 0, 4095, 0, 1);
      add_frame(2, 5, 0, 0);
      run_case("R3", 80, 70);

      // R4: limited range clamps at both ends
      set_cfg(1, 1, 0, 0, 2'd2);
      add_px(0, 0, 0, 1, 0); add_px(4095, 4095, 4095, 0, 0);
      add_px(4095, 0, 0, 0, 0); add_px(0, 0, 4095, 0, 1);
      add_frame(2, 4, 0, 0);
      run_case("R4", 60, 50);

      // R6: 4:2:2 with odd and even line lengths
      set_cfg(1, 0, 1, 0, 2'd2);
      add_frame(2, 5, 0, 0);
      add_frame(2, 4, 0, 0);
      add_frame(1, 1, 0, 0);
      run_case("R6", 90, 40);

      // R8 R11: 8-bit truncation without dither
      set_cfg(0, 0, 0, 0, 2'd0);
      add_frame(2, 5, 0, 0);
      run_case("R8/R11", 70, 70);

      // R8: 10-bit, then code 3 as 12-bit
      set_cfg(0, 0, 0, 0, 2'd1);
      add_frame(1, 6, 0, 0);
      run_case("R8", 70, 70);
      set_cfg(0, 0, 0, 0, 2'd3);
      add_frame(1, 6, 0, 0);
      run_case("R8", 70, 70);

      // R9: ordered offsets on a flat gray, 8 and 10 bit
      set_cfg(0, 0, 0, 1, 2'd0);
      add_frame(2, 4, 1, 1000);
      add_frame(2, 3, 1, 2002);
      run_case("R9", 100, 100);
      set_cfg(0, 0, 0, 1, 2'd1);
      add_frame(2, 4, 1, 1001);
      run_case("R9", 50, 50);

      // R10: saturation at the top code
      set_cfg(0, 0, 0, 1, 2'd0);
      add_frame(2, 2, 1, 4095);
      add_frame(2, 2, 1, 4093);
      run_case("R10", 80, 80);

      // R1: everything on, heavy backpressure
      set_cfg(1, 1, 1, 1, 2'd1);
      add_frame(3, 7, 0, 0);
      add_frame(2, 6, 0, 0);
      run_case("R1", 50, 25);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule